// File: doc/BRIEF.md
# Serial Signed Multiplier, Upper-Half Result

This block forms the product of two 16-bit two's-complement numbers with a bit-serial shift-and-add datapath. It retires one multiplier bit per clock. Only the upper half of the 32-bit signed product is returned. A client places both operands on the parallel inputs and raises `start` for one cycle. The operands are captured on that edge. Sixteen iteration cycles follow, and `done` then marks the cycle in which the new result appears.

The running partial product is one bit wider than an operand. Each cycle it shifts right arithmetically, and the retired low bit moves into the multiplier register as that register empties. On the multiplier's sign bit the multiplicand is subtracted rather than added. This corrects for the negative weight of that bit, so signed operands need no pre- or post-processing. The result is truncated, not rounded.

Top module: `smul_hi`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `busy` and `done` are 0 and `result` is 0x0000.
- R2: A `start` sampled high while `busy` is 0 captures `op_a` and `op_b`, and `busy` is 1 from the next cycle on.
- R3: `busy` stays high for exactly 16 consecutive cycles per operation. `done` is high for exactly one cycle, the first cycle after `busy` falls.
- R4: In the `done` cycle, `result` equals bits 31..16 of the signed 32-bit product op_a × op_b. It is truncated toward minus infinity, so it is never rounded.
- R5: While `busy` is 1, `start` and changes on `op_a`/`op_b` have no effect. The timing and the result of the running operation are those of the operands captured at its start.
- R6: `result` changes only on the edge that raises `done`. Between completions it holds its last value.
- R7: Multiplying -32768 (0x8000) by -32768 yields 0x4000 on `result`.
- R8: Negative operands are handled by subtracting the multiplicand on multiplier bit 15. For example, -1 × 1 gives 0xFFFF, and -32768 × 32767 gives 0xC000.
- R9: A `start` sampled in the `done` cycle is accepted, so operations can run back to back with one idle-to-busy edge between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin an operation; sampled only while idle |
| op_a | input | 16 | Multiplicand, two's complement |
| op_b | input | 16 | Multiplier, two's complement |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle marker of a new result |
| result | output | 16 | Upper half of the signed product |

## Verification
A wrong iteration count shows up at the ports as soon as `busy` falls, because the busy window is compared cycle by cycle against a behavioural model. A wrong sign correction or a wrong shift of the partial product shows only at the end of the operation, when the truncated upper half is compared with the exact product. For that reason the operands include negative multipliers and the most negative value. A faulty idle check would restart or corrupt the running operation. Pulsing `start` with new operands mid-operation exposes this within a cycle on `busy`, or at `done` on `result`.

// File: rtl/smul_pkg.sv
// Shared definitions for the serial signed multiplier.
// Assumes a single clock domain and operands of equal width.
package smul_pkg;
    localparam int unsigned SMUL_W = 16;
endpackage

// File: rtl/smul_ctrl.sv
// Sequencer: accepts start when idle, then counts W iteration cycles.
// Assumes W >= 2. It drives load (capture cycle), step (iteration) and
// last (final iteration) to the datapath.
module smul_ctrl #(
    parameter int unsigned W = smul_pkg::SMUL_W
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done,
    output logic load,
    output logic step,
    output logic last
);
    localparam int unsigned CW = (W > 2) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST_IDX = CW'(W - 1);

    logic [CW-1:0] cnt_q;
    logic          busy_q;
    logic          done_q;

    assign load = start && !busy_q;
    assign step = busy_q;
    assign last = busy_q && (cnt_q == LAST_IDX);
    assign busy = busy_q;
    assign done = done_q;

    // Iteration counter and busy/done flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (busy_q) begin
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == LAST_IDX) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end else if (start) begin
                busy_q <= 1'b1;
                cnt_q  <= '0;
            end
        end
    end
endmodule

// File: rtl/smul_datapath.sv
// Shift-and-add datapath. It holds the multiplicand, a multiplier register
// that also collects the retired low product bits, and a W+1 bit signed
// accumulator. Assumes load and step are never high together.
module smul_datapath #(
    parameter int unsigned W = smul_pkg::SMUL_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic         last,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic [W-1:0] result
);
    localparam int unsigned SW = W + 2;

    logic [W-1:0]  mcand_q;
    logic [W-1:0]  mplier_q;
    logic [W:0]    acc_q;
    logic [W-1:0]  res_q;
    logic [SW-1:0] mcand_ext;
    logic [SW-1:0] addend;
    logic [SW-1:0] sum;
    logic [W:0]    acc_d;
    logic [W-1:0]  mplier_d;

    // Adds or subtracts the multiplicand according to the current multiplier bit.
    always_comb begin
        mcand_ext = {{2{mcand_q[W-1]}}, mcand_q};
        if (!mplier_q[0])
            addend = '0;
        else if (last)
            addend = SW'(0) - mcand_ext;
        else
            addend = mcand_ext;
        sum      = {acc_q[W], acc_q} + addend;
        acc_d    = sum[SW-1:1];
        mplier_d = {sum[0], mplier_q[W-1:1]};
    end

    // Operand capture, per-bit iteration and result retirement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcand_q  <= '0;
            mplier_q <= '0;
            acc_q    <= '0;
            res_q    <= '0;
        end else if (load) begin
            mcand_q  <= op_a;
            mplier_q <= op_b;
            acc_q    <= '0;
        end else if (step) begin
            acc_q    <= acc_d;
            mplier_q <= mplier_d;
            if (last)
                res_q <= acc_d[W-1:0];
        end
    end

    assign result = res_q;
endmodule

// File: rtl/smul_hi.sv
// Top: serial two's-complement multiplier that returns the upper half of
// the 2W-bit product, one multiplier bit per clock. Synchronous
// active-low reset.
module smul_hi #(
    parameter int unsigned W = smul_pkg::SMUL_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] result
);
    logic load;
    logic step;
    logic last;

    smul_ctrl #(.W(W)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .busy(busy), .done(done), .load(load), .step(step), .last(last)
    );

    smul_datapath #(.W(W)) dp_i (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step), .last(last),
        .op_a(op_a), .op_b(op_b), .result(result)
    );
endmodule

// File: rtl/smul_hi_chk.sv
// Port-level protocol checker for smul_hi, attached with bind.
// It counts the busy window with its own counter, so no long $past is needed.
module smul_hi_chk #(
    parameter int unsigned W = smul_pkg::SMUL_W
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] result
);
    localparam int unsigned RW = $clog2(W + 2);
    logic [RW-1:0] run_q;

    // Length of the current busy window.
    always_ff @(posedge clk) begin
        if (!rst_n)    run_q <= '0;
        else if (busy) run_q <= run_q + 1'b1;
        else           run_q <= '0;
    end

    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_after_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));
    p_busy_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_q == RW'(W)));
    p_result_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));
endmodule

bind smul_hi smul_hi_chk #(.W(W)) chk_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .busy(busy), .done(done), .result(result)
);

// File: tb/smul_hi_tb_top.sv
module smul_hi_tb_top;
    localparam int W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic busy, done;
    logic [W-1:0] result;

    int n_checks = 0;
    int n_fails = 0;
    bit finished = 1'b0;

    // Behavioural reference state.
    bit m_busy = 1'b0, m_done = 1'b0;
    int m_cnt = 0;
    logic signed [W-1:0] m_a = '0, m_b = '0;
    logic [W-1:0] m_res = '0;

    always #4 clk = ~clk; // 125 MHz

    smul_hi #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
        .busy(busy), .done(done), .result(result)
    );

    function automatic logic [W-1:0] hi_of(input logic signed [W-1:0] a, input logic signed [W-1:0] b);
        logic signed [2*W-1:0] p;
        p = 32'(a) * 32'(b);
        return p[2*W-1:W];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model, advanced on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy <= 0; m_done <= 0; m_cnt <= 0; m_res <= '0;
        end else begin
            m_done <= 0;
            if (m_busy) begin
                m_cnt <= m_cnt + 1;
                if (m_cnt == W - 1) begin
                    m_busy <= 0; m_done <= 1; m_res <= hi_of(m_a, m_b);
                end
            end else if (start) begin
                m_busy <= 1; m_cnt <= 0; m_a <= op_a; m_b <= op_b;
            end
        end
    end

    // Cycle-by-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("R2/R5 busy", busy, m_busy);
            check("R3 done", done, m_done);
            check("R4/R6 result", result, m_res);
        end
    end

    task automatic run(input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] exp, input string req);
        @(negedge clk);
        start = 1; op_a = a; op_b = b;
        @(negedge clk);
        start = 0;
        while (!done) @(negedge clk);
        check(req, result, exp);
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++; n_fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 busy in reset", busy, 0);
        check("R1 done in reset", done, 0);
        check("R1 result in reset", result, 0);
        rst_n = 1;
        @(negedge clk);
        check("R1 busy after reset", busy, 0);
        check("R1 result after reset", result, 0);

        run(16'd3, 16'd5, 16'h0000, "R4 3*5");
        run(16'd12345, -16'sd321, hi_of(16'sd12345, -16'sd321), "R4 12345*-321");
        run(16'h7FFF, 16'h7FFF, 16'h3FFF, "R4 max*max");
        run(16'h8000, 16'h8000, 16'h4000, "R7 min*min");
        run(16'hFFFF, 16'h0001, 16'hFFFF, "R8 -1*1");
        run(16'h8000, 16'h7FFF, 16'hC000, "R8 min*max");
        run(16'h0001, 16'hFFFF, 16'hFFFF, "R8 1*-1");
        run(16'h1234, 16'h0000, 16'h0000, "R4 x*0");

        // R5: start and operand changes while busy are ignored.
        @(negedge clk);
        start = 1; op_a = 16'h4000; op_b = 16'h0004;
        @(negedge clk);
        start = 0;
        repeat (3) @(negedge clk);
        start = 1; op_a = 16'h7FFF; op_b = 16'h7FFF;
        @(negedge clk);
        check("R5 busy kept during restart", busy, 1);
        op_a = 16'h8000;
        @(negedge clk);
        start = 0;
        while (!done) @(negedge clk);
        check("R5 original operands used", result, 16'h0001);

        // R9: start in the done cycle is accepted.
        start = 1; op_a = 16'hFF00; op_b = 16'h0300;
        @(negedge clk);
        start = 0;
        check("R9 busy after start on done", busy, 1);
        while (!done) @(negedge clk);
        check("R9 back-to-back result", result, hi_of(16'shFF00, 16'sh0300));
        repeat (3) @(negedge clk);
        check("R6 result held", result, hi_of(16'shFF00, 16'sh0300));

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule